// File: doc/BRIEF.md
# Posted-Write Register Bridge

The bridge sits between a fast bus-clock register port and a bank of registers held in a slower functional clock domain. Each functional register has its own crossing lane. A write to one of these registers is held in the lane's data latch. A request toggle then carries it across the clock boundary, and an acknowledge toggle comes back once the value has landed. The bus side reports the lane as pending from the accepting edge until that acknowledge arrives. Software reads the pending status word to know when a lane is free.

One mode bit in the interface-control register picks how the bus sees the write. With the bit set, a write to a free lane is accepted in the same cycle, and the bus is free to go on while the value travels. With the bit clear, ready stays low until the value has landed and the acknowledge is back. In both modes a write to a lane that is still pending is held off until that lane is free. Bus reads of crossing registers return the functional-domain value as it stands, with no wait. This value is only meaningful once the lane's pending bit is clear.

The wake-up enable and interface-control registers live in the bus domain. Writes to them take effect at once and have no pending flag. The functional register contents and a one-cycle landing strobe per lane are brought out for the logic that uses them.

Top module: `wp_bridge`

## Requirements
- R1: After reset the pending status word reads 0, interface control reads 0 (stalling mode), the wake-up enable register and all functional registers are 0, and no landing strobe is high.
- R2: Interface control sits at word address 17. Only its bit 2 is stored, and it selects posted mode when 1. Every other bit reads back 0.
- R3: In posted mode a write to crossing register i (word address i, 0 to 9) with pending bit i clear is accepted with ready high in the same cycle. Bit i of the pending status word (address 18) reads 1 from the next cycle on. The bit order is control 0, counter 1, load 2, trigger 3, match 4, positive increment 5, negative increment 6, tick count 7, overflow count 8, overflow wrap 9.
- R4: An accepted write updates the functional register on the third functional-clock rising edge after the accepting bus edge, and not before. The lane's landing strobe is high for exactly that one functional cycle.
- R5: A pending bit clears only after the acknowledge returns. Once it is clear, a bus read of that register returns the written value.
- R6: A write to a register whose pending bit is set is held with ready low until the bit clears. It is then accepted, and the register ends with the second value.
- R7: With posted mode off, a write to a crossing register keeps ready low for at least 4 cycles, until the value has landed. On completion the pending bit is already clear and the functional register holds the new value.
- R8: Writes to different crossing registers may be in flight together. Each is tracked by its own pending bit, and each lands with its own value.
- R9: Writes to the wake-up enable register (address 16) complete with ready high at once, drive the wake-up enable output from the next cycle, and set no pending bit. Writes to the pending status word are ignored.
- R10: Status bits 10 and above read 0. Unmapped addresses read 0, and writes to them complete at once with no effect on any register or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| fn_clk | input | 1 | Slow functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_sel | input | 1 | Access request, held until ready is high |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (5) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for the addressed register |
| bus_ready | output | 1 | Access completes on a clock edge where this is high |
| fn_regs | output | NP*DW (320) | Functional register contents, register i in bits i*DW upward |
| fn_wr_strobe | output | NP (10) | One functional-cycle pulse per lane when a write lands |
| wake_en | output | DW (32) | Wake-up enable register contents |

## Verification
The hardest case to reach is a second write hitting a lane whose first write is still crossing. To reach it, the bench issues two posted writes to the same register on back-to-back bus cycles. This lands inside the three-functional-edge window. The bench also mixes random register indices in long posted bursts, so that repeats of a lane still in flight arise naturally. The landing-edge rule is checked by counting functional rising edges from the accepting bus edge. The clock phases are chosen so that no edges coincide.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned ADDR_WAKE   = 16;
  localparam int unsigned ADDR_IFCTRL = 17;
  localparam int unsigned ADDR_PEND   = 18;
  localparam int unsigned POSTED_BIT  = 2;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_POSTED = 2'd1,
    TGT_LOCAL  = 2'd2,
    TGT_STATUS = 2'd3
  } tgt_e;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/wp_lane.sv
module wp_lane #(
  parameter int unsigned DW = 32
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          fn_clk,
  input  logic          fn_rst_n,
  input  logic          launch,
  input  logic [DW-1:0] wdata,
  output logic          pending,
  output logic [DW-1:0] fn_q,
  output logic          fn_strobe
);
  // bus side
  logic          req_q, req_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          ack_s;
  // functional side
  logic          req_s;
  logic          ack_q, ack_d;
  logic [DW-1:0] fnq_q, fnq_d;
  logic          strobe_q, strobe_d;
  logic          new_req;

  always_comb begin
    req_d  = req_q ^ launch;
    hold_d = launch ? wdata : hold_q;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q <= req_d;
      if (launch) hold_q <= hold_d;
    end
  end

  wp_sync #(.W(1)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_q), .q(ack_s)
  );

  assign pending = req_q ^ ack_s;

  wp_sync #(.W(1)) u_req_sync (
    .clk(fn_clk), .rst_n(fn_rst_n), .d(req_q), .q(req_s)
  );

  always_comb begin
    new_req  = req_s ^ ack_q;
    ack_d    = req_s;
    fnq_d    = new_req ? hold_q : fnq_q;
    strobe_d = new_req;
  end

  always_ff @(posedge fn_clk or negedge fn_rst_n) begin
    if (!fn_rst_n) begin
      ack_q    <= 1'b0;
      fnq_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      ack_q    <= ack_d;
      strobe_q <= strobe_d;
      if (new_req) fnq_q <= fnq_d;
    end
  end

  assign fn_q      = fnq_q;
  assign fn_strobe = strobe_q;

  // R6: the controller never starts a transfer on a busy lane
  a_r6_no_launch_while_pending: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n) launch |-> !pending)
    else $error("launch on a pending lane");

  // R3: a launched write shows as pending on the next cycle
  a_r3_pending_after_launch: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n) launch |=> pending)
    else $error("pending not set after launch");

  // R5: the crossing data stays put while the lane is busy
  a_r5_hold_stable: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n) pending |=> $stable(hold_q))
    else $error("held data changed while pending");

  // R4: one landing pulse per crossing
  a_r4_single_strobe: assert property (
    @(posedge fn_clk) disable iff (!fn_rst_n) fn_strobe |=> !fn_strobe)
    else $error("landing strobe longer than one cycle");
endmodule

// File: rtl/wp_bus_ctrl.sv
module wp_bus_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned NP = 10,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [NP-1:0]    pending,
  input  logic [NP*DW-1:0] fn_flat,
  output logic [NP-1:0]    launch,
  output logic             bus_ready,
  output logic [DW-1:0]    bus_rdata,
  output logic [DW-1:0]    wake_en
);
  localparam logic [AW-1:0] A_WAKE   = AW'(ADDR_WAKE);
  localparam logic [AW-1:0] A_IFCTRL = AW'(ADDR_IFCTRL);
  localparam logic [AW-1:0] A_PEND   = AW'(ADDR_PEND);

  tgt_e          tgt;
  logic          wr_req;
  logic          pend_t;
  logic [NP-1:0] sel_oh;
  logic          ifctrl_q, ifctrl_d;
  logic [DW-1:0] wake_q, wake_d;
  logic          np_busy_q, np_busy_d;
  logic          ifctrl_we, wake_we;

  always_comb begin
    sel_oh = '0;
    for (int i = 0; i < NP; i++) sel_oh[i] = (bus_addr == AW'(i));
  end

  always_comb begin
    if (|sel_oh)                                        tgt = TGT_POSTED;
    else if (bus_addr == A_WAKE || bus_addr == A_IFCTRL) tgt = TGT_LOCAL;
    else if (bus_addr == A_PEND)                         tgt = TGT_STATUS;
    else                                                 tgt = TGT_NONE;
  end

  assign wr_req = bus_sel && bus_wr;
  assign pend_t = |(sel_oh & pending);

  always_comb begin
    launch    = '0;
    bus_ready = 1'b1;
    np_busy_d = np_busy_q;
    if (wr_req && tgt == TGT_POSTED) begin
      if (ifctrl_q) begin
        bus_ready = !pend_t;
        if (!pend_t) launch = sel_oh;
      end else if (!np_busy_q) begin
        bus_ready = 1'b0;
        if (!pend_t) begin
          launch    = sel_oh;
          np_busy_d = 1'b1;
        end
      end else begin
        bus_ready = !pend_t;
        if (!pend_t) np_busy_d = 1'b0;
      end
    end
  end

  always_comb begin
    ifctrl_we = wr_req && bus_addr == A_IFCTRL;
    wake_we   = wr_req && bus_addr == A_WAKE;
    ifctrl_d  = bus_wdata[POSTED_BIT];
    wake_d    = bus_wdata;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ifctrl_q  <= 1'b0;
      wake_q    <= '0;
      np_busy_q <= 1'b0;
    end else begin
      np_busy_q <= np_busy_d;
      if (ifctrl_we) ifctrl_q <= ifctrl_d;
      if (wake_we)   wake_q   <= wake_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (tgt)
      TGT_POSTED: begin
        for (int i = 0; i < NP; i++)
          if (sel_oh[i]) bus_rdata = fn_flat[i*DW +: DW];
      end
      TGT_LOCAL: begin
        if (bus_addr == A_WAKE) bus_rdata = wake_q;
        else                    bus_rdata[POSTED_BIT] = ifctrl_q;
      end
      TGT_STATUS: bus_rdata[NP-1:0] = pending;
      default:    bus_rdata = '0;
    endcase
  end

  assign wake_en = wake_q;

  // R8: at most one lane starts per cycle
  a_r8_single_launch: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n) $onehot0(launch))
    else $error("more than one lane launched");

  // R7: a stalled write is not completed twice: once done, the busy state is gone
  a_r7_np_done_clears: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n)
      (np_busy_q && bus_ready && wr_req) |=> !np_busy_q)
    else $error("stall state not released");
endmodule

// File: rtl/wp_bridge.sv
module wp_bridge #(
  parameter int unsigned NP = 10,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic             bus_clk,
  input  logic             fn_clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_ready,
  output logic [NP*DW-1:0] fn_regs,
  output logic [NP-1:0]    fn_wr_strobe,
  output logic [DW-1:0]    wake_en
);
  logic          bus_rst_n, fn_rst_n;
  logic [NP-1:0] launch, pending;

  wp_rst_sync u_bus_rst (.clk(bus_clk), .arst_n(rst_n), .srst_n(bus_rst_n));
  wp_rst_sync u_fn_rst  (.clk(fn_clk),  .arst_n(rst_n), .srst_n(fn_rst_n));

  wp_bus_ctrl #(.NP(NP), .DW(DW), .AW(AW)) u_ctrl (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pending   (pending),
    .fn_flat   (fn_regs),
    .launch    (launch),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .wake_en   (wake_en)
  );

  for (genvar g = 0; g < NP; g++) begin : g_lane
    wp_lane #(.DW(DW)) u_lane (
      .bus_clk   (bus_clk),
      .bus_rst_n (bus_rst_n),
      .fn_clk    (fn_clk),
      .fn_rst_n  (fn_rst_n),
      .launch    (launch[g]),
      .wdata     (bus_wdata),
      .pending   (pending[g]),
      .fn_q      (fn_regs[g*DW +: DW]),
      .fn_strobe (fn_wr_strobe[g])
    );
  end

  // R9 / R10: writes outside the crossing range never start a lane
  a_r9_local_no_launch: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_sel && bus_wr && bus_addr >= AW'(NP)) |-> (launch == '0))
    else $error("non-crossing write started a lane");
endmodule

// File: tb/sim_wp_bridge.sv
module sim_wp_bridge;
  localparam int NP = 10, DW = 32, AW = 5;

  logic bus_clk = 1'b0, fn_clk = 1'b0, rst_n;
  logic bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_ready;
  logic [NP*DW-1:0] fn_regs;
  logic [NP-1:0] fn_wr_strobe;
  logic [DW-1:0] wake_en;

  int n_checks = 0, n_fail = 0;
  logic [DW-1:0] model [NP];

  always #10 bus_clk = ~bus_clk;
  always #35 fn_clk  = ~fn_clk;

  wp_bridge #(.NP(NP), .DW(DW), .AW(AW)) u0 (
    .bus_clk(bus_clk), .fn_clk(fn_clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .fn_regs(fn_regs), .fn_wr_strobe(fn_wr_strobe), .wake_en(wake_en)
  );

  function automatic logic [DW-1:0] fn_of(input int i);
    return fn_regs[i*DW +: DW];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d, output int waits);
    logic r;
    waits = 0;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    forever begin
      @(negedge bus_clk); r = bus_ready;
      @(posedge bus_clk);
      if (r) break;
      waits++;
      if (waits > 2000) break;
    end
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge bus_clk); d = bus_rdata;
    @(posedge bus_clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [DW-1:0] s;
    int n = 0;
    do begin
      bus_read(18, s);
      n++;
    end while (s != 0 && n < 400);
    check(tag, s, 32'h0);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd, d;
    int w, idx;
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) model[i] = '0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge fn_clk);
    @(posedge bus_clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge fn_clk);
    @(posedge bus_clk); #1;

    // R1 reset state
    bus_read(18, rd); check("R1 status", rd, 32'h0);
    bus_read(17, rd); check("R1 ifctrl", rd, 32'h0);
    bus_read(16, rd); check("R1 wake", rd, 32'h0);
    check("R1 wake port", wake_en, 32'h0);
    check("R1 strobe", {22'h0, fn_wr_strobe}, 32'h0);
    for (int i = 0; i < NP; i++) check("R1 fn reg", fn_of(i), 32'h0);

    // R7 stalling mode
    bus_write(3, 32'h1234_5678, w); model[3] = 32'h1234_5678;
    check("R7 stalled", 32'(w >= 4), 32'h1);
    check("R7 landed", fn_of(3), 32'h1234_5678);
    bus_read(18, rd); check("R7 pending clear", rd, 32'h0);

    // R2 interface control
    bus_write(17, 32'hFFFF_FFFB, w); bus_read(17, rd); check("R2 bit2 clear", rd, 32'h0);
    bus_write(17, 32'hFFFF_FFFF, w); bus_read(17, rd); check("R2 only bit2", rd, 32'h4);

    // R3 posted accept
    bus_write(0, 32'hA0A0_0001, w); model[0] = 32'hA0A0_0001;
    check("R3 no wait", w, 0);
    bus_read(18, rd); check("R3 pending bit0", rd, 32'h1);

    // R4 landing edge
    bus_write(5, 32'h5555_AAAA, w); model[5] = 32'h5555_AAAA;
    check("R4 no wait", w, 0);
    repeat (2) @(posedge fn_clk);
    #1 check("R4 not early", fn_of(5), 32'h0);
    @(posedge fn_clk);
    #1 check("R4 third edge", fn_of(5), 32'h5555_AAAA);
    check("R4 strobe", {31'h0, fn_wr_strobe[5]}, 32'h1);
    @(posedge fn_clk);
    #1 check("R4 strobe one cycle", {31'h0, fn_wr_strobe[5]}, 32'h0);
    @(posedge bus_clk); #1;

    // R5 read after clear
    wait_idle("R5 idle");
    bus_read(5, rd); check("R5 read back", rd, 32'h5555_AAAA);
    bus_read(0, rd); check("R5 read back 0", rd, 32'hA0A0_0001);

    // R6 second write held
    bus_write(2, 32'h1111_1111, w); check("R6 first accepted", w, 0);
    bus_write(2, 32'h2222_2222, w); model[2] = 32'h2222_2222;
    check("R6 held", 32'(w > 0), 32'h1);
    bus_read(18, rd); check("R6 pending after second", rd, 32'h4);
    wait_idle("R6 idle");
    check("R6 final", fn_of(2), 32'h2222_2222);

    // R8 several in flight
    bus_write(1, 32'h0000_0011, w); model[1] = 32'h11;
    bus_write(4, 32'h0000_0044, w); model[4] = 32'h44;
    bus_write(7, 32'h0000_0077, w); model[7] = 32'h77;
    bus_write(9, 32'h0000_0099, w); model[9] = 32'h99;
    check("R8 no wait", w, 0);
    bus_read(18, rd); check("R8 flags", rd, 32'h292);
    wait_idle("R8 idle");
    for (int i = 0; i < NP; i++) check("R8 values", fn_of(i), model[i]);

    // R9 local registers
    bus_write(16, 32'hA5A5_0F0F, w); check("R9 wake no wait", w, 0);
    check("R9 wake port", wake_en, 32'hA5A5_0F0F);
    bus_read(18, rd); check("R9 no pending", rd, 32'h0);
    bus_write(18, 32'h0000_03FF, w); bus_read(18, rd); check("R9 status ro", rd, 32'h0);
    bus_read(16, rd); check("R9 wake read", rd, 32'hA5A5_0F0F);

    // R10 unmapped
    bus_write(25, 32'hDEAD_BEEF, w); check("R10 no wait", w, 0);
    bus_read(25, rd); check("R10 read zero", rd, 32'h0);
    bus_read(18, rd); check("R10 no pending", rd, 32'h0);
    check("R10 wake kept", wake_en, 32'hA5A5_0F0F);

    // R8 random posted bursts
    for (int k = 0; k < 40; k++) begin
      idx = $urandom_range(NP - 1); d = $urandom;
      bus_write(idx, d, w); model[idx] = d;
    end
    wait_idle("R8 random idle");
    for (int i = 0; i < NP; i++) check("R8 random values", fn_of(i), model[i]);

    // R7 random stalling writes
    bus_write(17, 32'h0, w);
    for (int k = 0; k < 10; k++) begin
      idx = $urandom_range(NP - 1); d = $urandom;
      bus_write(idx, d, w); model[idx] = d;
      check("R7 random stall", 32'(w >= 4), 32'h1);
      check("R7 random landed", fn_of(idx), d);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule